// File: doc/BRIEF.md
# Condition Flag and Branch Evaluator

This block is a 32-bit add/subtract/compare unit. It keeps the four condition flags it produces in a status word, and it decides from those flags whether a conditional branch is taken. In each cycle the caller presents two operands, an operation code and a flag-update enable. The result and the flags are captured together on the next rising clock edge. Subtraction adds the inverted second operand plus one. Signed overflow is taken from the carries into and out of the most-significant bit.

A compare runs the same subtraction but keeps the previous result. It exists only to move the flags. A two-bit condition select picks one of four branch tests: equal, not equal, minus and plus. The branch-taken output is always judged from the registered flags, so a branch decision reflects the last operation that was allowed to update them.

Top module: `cfe_core`

## Requirements
- R1: With `op_sel` = 0 (add), or with the reserved code 3, which acts as add, `result` equals `op_a + op_b` modulo 2^32 after the next rising edge.
- R2: With `op_sel` = 1 (subtract), `result` equals `op_a + ~op_b + 1` (that is, `op_a - op_b` modulo 2^32) after the next rising edge.
- R3: With `op_sel` = 2 (compare), `result` keeps its previous value, while the flags take the values of `op_a - op_b` if `flag_en` is high.
- R4: Negative flag N equals bit 31 of the computed value. Zero flag Z is 1 exactly when all 32 bits of the computed value are 0.
- R5: Carry flag C is the carry out of bit 31 of the adder. For subtract and compare, C is 1 exactly when `op_a >= op_b` as unsigned numbers.
- R6: Overflow flag V is 1 exactly when the carry into bit 31 differs from the carry out of bit 31. This is the case when both adder inputs have the same sign and the sum has the other sign.
- R7: The flags change only on a rising edge where `flag_en` is 1. When `flag_en` is 0 they keep their values, even while the result changes.
- R8: `br_taken` is computed from the registered flags. `br_cond` 0 (equal) is taken when Z=1, 1 (not equal) when Z=0, 2 (minus) when N=1 and 3 (plus) when N=0.
- R9: `status` carries N in bit 31, Z in bit 30, C in bit 29 and V in bit 28. Bits 27 to 0 are always 0.
- R10: When `rst_n` is low at a rising edge, all four flags and `result` are cleared to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| op_sel | input | 2 | 0 add, 1 subtract, 2 compare, 3 add |
| flag_en | input | 1 | Allows the flags to be written at the next edge |
| br_cond | input | 2 | Branch test: 0 equal, 1 not equal, 2 minus, 3 plus |
| result | output | 32 | Registered arithmetic result |
| status | output | 32 | Status word with the flags in bits 31..28 |
| br_taken | output | 1 | Branch decision from the registered flags |

## Verification
The hardest state to reach is one where the flags no longer match the visible result. That happens after a compare, or after an add performed with the flag update disabled. In both cases the branch decision has to follow the older flags and not the value on `result`. The directed sequences build this state on purpose. One sequence sets Z with an equal compare and then performs a non-zero add with `flag_en` low. Another places a compare between two arithmetic operations. All four branch selects are then swept against flags whose values the bench already knows. Signed-overflow corners, 0x7FFFFFFF + 1 and 0x80000000 - 1, separate the V flag from the C flag.

// File: rtl/cfe_pkg.sv
// Package for the condition flag unit.
// Holds the operation codes, the branch test codes and the flag bundle.
// Assumes a 2-bit operation select and a 2-bit branch select.
package cfe_pkg;
    typedef enum logic [1:0] {
        OP_ADD  = 2'd0,
        OP_SUB  = 2'd1,
        OP_CMP  = 2'd2,
        OP_ADD2 = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        BR_EQ = 2'd0,
        BR_NE = 2'd1,
        BR_MI = 2'd2,
        BR_PL = 2'd3
    } br_e;

    typedef struct packed {
        logic neg;
        logic zero;
        logic carry;
        logic ovf;
    } flags_t;

    localparam int FLAG_COUNT = 4;
endpackage

// File: rtl/cfe_addsub.sv
// Adder/subtractor with explicit carries at the top bit.
// Subtraction is done as a + ~b + 1. The carry into the top bit and the carry
// out of it are produced separately, so overflow is their XOR.
// Assumes W >= 2. The block is purely combinational.
module cfe_addsub #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] sum,
    output logic         carry_out,
    output logic         overflow
);
    logic [W-1:0] b_eff;
    logic [W-1:0] low_sum;   // W-1 sum bits plus the carry into the top bit
    logic [1:0]   top_sum;

    // Select the true or the inverted second operand.
    always_comb b_eff = sub ? ~b : b;

    // Add the lower W-1 bits; the carry-in is 1 for a subtraction.
    always_comb low_sum = {1'b0, a[W-2:0]} + {1'b0, b_eff[W-2:0]} + {{(W-1){1'b0}}, sub};

    // Add the top bit, taking the carry from the lower part.
    always_comb top_sum = {1'b0, a[W-1]} + {1'b0, b_eff[W-1]} + {1'b0, low_sum[W-1]};

    // Put the sum together and derive the carry and overflow outputs.
    always_comb begin
        sum       = {top_sum[0], low_sum[W-2:0]};
        carry_out = top_sum[1];
        overflow  = top_sum[1] ^ low_sum[W-1];
    end
endmodule

// File: rtl/cfe_flag_reg.sv
// Condition flag register.
// Loads the new flags when the enable is high and holds them otherwise.
// Reset is synchronous and active low, and clears every flag.
module cfe_flag_reg
    import cfe_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   load,
    input  flags_t next_flags,
    output flags_t flags
);
    // Store the flags; load them only when enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags <= '0;
        end else if (load) begin
            flags <= next_flags;
        end
    end

    // R7: flags keep their value on an edge without the enable
    a_r7_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && $past(rst_n)) |=> $stable(flags));

    // R7: flags follow the loaded value on an enabled edge
    a_r7_load_follows: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (flags == $past(next_flags)));
endmodule

// File: rtl/cfe_cond_eval.sv
// Branch condition evaluator.
// Makes the taken decision for one of four tests on the stored flags.
// Assumes the flags come from a register, so the output does not depend on
// the current arithmetic result.
module cfe_cond_eval
    import cfe_pkg::*;
(
    input  flags_t     flags,
    input  logic [1:0] cond,
    output logic       taken
);
    // Decode the branch test from the selected flag.
    always_comb begin
        unique case (br_e'(cond))
            BR_EQ:   taken =  flags.zero;
            BR_NE:   taken = !flags.zero;
            BR_MI:   taken =  flags.neg;
            BR_PL:   taken = !flags.neg;
            default: taken = 1'b0;
        endcase
    end
endmodule

// File: rtl/cfe_core.sv
// Top level of the condition flag and branch evaluator.
// Runs add, subtract or compare and registers the result (compare leaves the
// result alone). The flags are written when flag_en is high and are placed in
// the top bits of the status word. The branch decision is made from those flags.
// Reset is synchronous and active low.
module cfe_core
    import cfe_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    input  logic [1:0]   op_sel,
    input  logic         flag_en,
    input  logic [1:0]   br_cond,
    output logic [W-1:0] result,
    output logic [W-1:0] status,
    output logic         br_taken
);
    localparam int PAD = W - FLAG_COUNT;

    logic         is_sub;
    logic         is_cmp;
    logic [W-1:0] sum;
    logic         carry_out;
    logic         overflow;
    flags_t       next_flags;
    flags_t       flags;

    // Decode the operation select.
    always_comb begin
        is_cmp = (op_e'(op_sel) == OP_CMP);
        is_sub = (op_e'(op_sel) == OP_SUB) || is_cmp;
    end

    cfe_addsub #(.W(W)) u_addsub (
        .a         (op_a),
        .b         (op_b),
        .sub       (is_sub),
        .sum       (sum),
        .carry_out (carry_out),
        .overflow  (overflow)
    );

    // Build the candidate flags from the adder output.
    always_comb begin
        next_flags.neg   = sum[W-1];
        next_flags.zero  = (sum == '0);
        next_flags.carry = carry_out;
        next_flags.ovf   = overflow;
    end

    cfe_flag_reg u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (flag_en),
        .next_flags (next_flags),
        .flags      (flags)
    );

    // Register the result; a compare leaves it unchanged.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result <= '0;
        end else if (!is_cmp) begin
            result <= sum;
        end
    end

    // Put the flags at the top of the status word.
    always_comb status = {flags, {PAD{1'b0}}};

    cfe_cond_eval u_cond (
        .flags (flags),
        .cond  (br_cond),
        .taken (br_taken)
    );

    // Reference sign-rule overflow, used only by the assertion below.
    logic b_sign_eff;
    logic ovf_ref;
    always_comb begin
        b_sign_eff = is_sub ? ~op_b[W-1] : op_b[W-1];
        ovf_ref    = (op_a[W-1] == b_sign_eff) && (sum[W-1] != op_a[W-1]);
    end

    // R3: a compare keeps the previous result
    a_r3_cmp_keeps_result: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == 2'd2) |=> $stable(result));

    // R4: an enabled compare of equal operands sets Z and clears N
    a_r4_equal_sets_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_en && op_sel == 2'd2 && op_a == op_b) |=> (status[W-2] && !status[W-1]));

    // R6: the carry-based overflow agrees with the sign rule
    a_r6_ovf_sign_rule: assert property (@(posedge clk) disable iff (!rst_n)
        flag_en |=> (status[W-4] == $past(ovf_ref)));

    // R9: the status bits below the flags are always zero
    a_r9_low_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
        status[PAD-1:0] == '0);
endmodule

// File: tb/cfe_core_test.sv
`timescale 1ns/1ps
module cfe_core_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic [1:0]  op_sel = 2'd2;
    logic        flag_en = 1'b0;
    logic [1:0]  br_cond = 2'd0;
    logic [31:0] result;
    logic [31:0] status;
    logic        br_taken;

    int checks = 0;
    int errors = 0;
    logic [31:0] exp_res = '0;
    logic [3:0]  exp_flg = '0;   // {N,Z,C,V}
    bit          done = 0;

    always #2.5 clk = ~clk;

    cfe_core uut (
        .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .op_sel(op_sel),
        .flag_en(flag_en), .br_cond(br_cond), .result(result), .status(status),
        .br_taken(br_taken)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Reference model: wide arithmetic and the sign rule for overflow.
    task automatic model(input logic [31:0] a, input logic [31:0] b, input logic [1:0] op, input logic en);
        logic [32:0] wide;
        logic [31:0] r;
        logic        bs;
        if (op == 2'd1 || op == 2'd2) begin
            wide = {1'b0, a} - {1'b0, b};
            r = wide[31:0];
            bs = ~b[31];
            wide[32] = (a >= b);
        end else begin
            wide = {1'b0, a} + {1'b0, b};
            r = wide[31:0];
            bs = b[31];
        end
        if (op != 2'd2) exp_res = r;
        if (en) exp_flg = {r[31], r == 32'd0, wide[32], (a[31] == bs) && (r[31] != a[31])};
    endtask

    // One operation, then an idle cycle in which nothing is written.
    task automatic do_op(input logic [31:0] a, input logic [31:0] b, input logic [1:0] op, input logic en, input string req);
        @(negedge clk);
        op_a = a; op_b = b; op_sel = op; flag_en = en;
        @(negedge clk);
        op_sel = 2'd2; flag_en = 1'b0;
        model(a, b, op, en);
        check({req, " result"}, result, exp_res);
        check({req, " flags"}, {28'd0, status[31:28]}, {28'd0, exp_flg});
    endtask

    // Sweep all four branch tests against the expected flags (R8).
    task automatic check_branches(input string tag);
        for (int c = 0; c < 4; c++) begin
            logic e;
            br_cond = c[1:0];
            #0.5;
            case (c)
                0: e = exp_flg[2];
                1: e = !exp_flg[2];
                2: e = exp_flg[3];
                default: e = !exp_flg[3];
            endcase
            check({"R8 ", tag}, {31'd0, br_taken}, {31'd0, e});
        end
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        exp_res = '0; exp_flg = '0;
        check("R10 result reset", result, 32'd0);
        check("R10 R9 status reset", status, 32'd0);
    endtask

    task automatic t_add;
        do_op(32'd1, 32'd2, 2'd0, 1'b1, "R1 add");
        do_op(32'hFFFF_FFFF, 32'd1, 2'd0, 1'b1, "R4 R5 add wrap zero");
        do_op(32'h7FFF_FFFF, 32'd1, 2'd0, 1'b1, "R6 add overflow");
        do_op(32'h8000_0000, 32'h8000_0000, 2'd0, 1'b1, "R5 R6 add neg overflow");
        do_op(32'd10, 32'd20, 2'd3, 1'b1, "R1 code3 add");
        check_branches("after add");
    endtask

    task automatic t_sub;
        do_op(32'd4, 32'd1, 2'd1, 1'b1, "R2 R5 sub no borrow");
        do_op(32'd1, 32'd4, 2'd1, 1'b1, "R2 R4 sub negative");
        check_branches("negative");
        do_op(32'h8000_0000, 32'd1, 2'd1, 1'b1, "R6 sub overflow");
        do_op(32'd7, 32'd7, 2'd1, 1'b1, "R2 R4 sub zero");
    endtask

    task automatic t_cmp;
        do_op(32'd55, 32'd3, 2'd0, 1'b1, "R1 pre-compare");
        do_op(32'h1234, 32'h1234, 2'd2, 1'b1, "R3 cmp equal");
        check("R3 result kept", result, 32'd58);
        check_branches("cmp equal");
        do_op(32'd2, 32'd9, 2'd2, 1'b1, "R3 cmp less");
        check_branches("cmp less");
    endtask

    task automatic t_hold;
        do_op(32'd0, 32'd0, 2'd0, 1'b1, "R4 zero sum");
        do_op(32'h9000_0000, 32'd5, 2'd0, 1'b0, "R7 add no update");
        check("R7 Z held", {31'd0, status[30]}, 32'd1);
        check_branches("held flags");
        do_op(32'd3, 32'd3, 2'd2, 1'b0, "R7 cmp no update");
    endtask

    task automatic t_status;
        do_op(32'h7FFF_FFFF, 32'hFFFF_FFFF, 2'd1, 1'b1, "R9 sub");
        check("R9 status layout", status, 32'h9000_0000);
    endtask

    initial begin : watchdog
        #(5.0 * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_add();
        t_sub();
        t_cmp();
        t_hold();
        t_status();
        t_reset();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule